// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 memory controller and its PHY out of reset after power-up, with no processor involved. It drives a single-beat register-write port (address, 32-bit data, valid, ready) toward the controller. The writes run in a fixed order:

- switch on the PHY clock;
- reset the PHY and launch its calibration;
- send twelve DRAM command words;
- load the timing, latency and configuration registers.

A programmable wait separates the phases.

Each command word carries an 8-bit command code in bits [23:16] and a 16-bit argument in bits [15:0]. Bits [31:24] are zero. Two of the commands take their arguments from a 32-bit mode word:

- the second mode-register write uses the low half of the mode word;
- the last extended-mode write merges the upper half of the mode word into its argument.

After the final configuration write is accepted, the block raises `done` and holds it until reset. Register addresses, bit positions, command codes, argument constants and the wait length are all parameters. A parameter also selects whether the sequence waits for a `start` pulse.

Top module: `ddr2_boot_seq`

## Requirements
- R1: After a synchronous reset the block presents no write and holds `busy` and `done` low until `start` is seen high on a clock edge (with `USE_START`=1).
- R2: Between the edge that accepts `start` and the first write, `busy` is high and `wr_valid` is low for exactly `DELAY_CNT` cycles.
- R3: The first write goes to the PHY-configuration address (default 0x00) with only the clock-enable bit set (bit 0, data 0x0000_0001). A full wait of `DELAY_CNT` idle cycles follows it.
- R4: Two PHY-control writes (default address 0x04) follow with no cycle between them. The first sets the PHY-reset bit (bit 0) and the calibration-reset bit (bit 1), giving 0x3. The second sets only the calibration-go bit (bit 2), giving 0x4. A full wait follows the second.
- R5: Twelve writes go to the command address (default 0x08), each with data = code<<16 | argument. The command order is: deselect/0, precharge/all, EMRS2/0, EMRS3/0, EMRS/DLL-on, MRS/DLL-reset, precharge/all, refresh/0, refresh/0, MRS/mode, EMRS/OCD-default|DLL-on, EMRS/OCD-exit|DLL-on|mode-high. The default codes are deselect 0x00, precharge 0x01, refresh 0x02, MRS 0x03, EMRS 0x04, EMRS2 0x05 and EMRS3 0x06. The default arguments are precharge-all 0x0400, DLL-on 0x0001, DLL-reset 0x0100, OCD-default 0x0380 and OCD-exit 0x0040.
- R6: The tenth command's argument is `mode_cfg[15:0]`. The twelfth command's argument is OCD-exit | DLL-on | `mode_cfg[31:16]`.
- R7: After every command write, the last one included, the port stays idle with `busy` high for exactly `DELAY_CNT` cycles.
- R8: After the command phase the block writes `timing_cfg`, then `latency_cfg`, then `ctrl_cfg`, to addresses 0x0C, 0x10 and 0x14 (defaults). These three writes run back to back with no idle cycle between them.
- R9: While `wr_valid` is high and `wr_ready` is low, the address and data hold steady. A write counts only on a cycle where both are high. A full run makes exactly 18 writes.
- R10: `done` rises on the cycle after the configuration write is accepted and stays high until reset. `busy` is high from the edge that accepts `start` until that point. `done` and `busy` are never both high.
- R11: A synchronous reset in the middle of a run drops `wr_valid`, `busy` and `done` on the next cycle. The following `start` replays the whole sequence from the PHY clock write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Launches the sequence from idle (ignored when `USE_START`=0) |
| mode_cfg | input | 32 | Mode word: low half is the MRS argument, high half is merged into the final EMRS |
| timing_cfg | input | 32 | Value for the timing register |
| latency_cfg | input | 32 | Value for the latency register |
| ctrl_cfg | input | 32 | Value for the configuration register |
| wr_valid | output | 1 | A register write is presented |
| wr_ready | input | 1 | The controller accepts the presented write |
| wr_addr | output | ADDR_W | Register address of the write |
| wr_data | output | 32 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete, sticky until reset |

## Verification
The full 18-write sequence runs with a short wait under three acceptance patterns:

- The always-ready pattern gives the exact idle gap after each step, which separates paused steps from back-to-back ones.
- The pattern that accepts one cycle in three holds each write across several stall cycles. This tests that address and data stay steady and that a stalled write never advances the step.
- The pattern that stalls one cycle in three moves the stalls to other steps of the script.

Each run uses a different mode word, chosen so that the low-half MRS argument and the high-half merge into the last EMRS cannot be confused with each other or with the constant arguments. One run is cut off by a reset partway through the command list. This tests that the replay starts from the first step and not from where the run stopped.

// File: rtl/ddr2_boot_pkg.sv
package ddr2_boot_pkg;

   // sequencer states
   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_WAIT  = 2'd1,
      SEQ_WRITE = 2'd2,
      SEQ_DONE  = 2'd3
   } seq_state_t;

   // kinds of DRAM command carried in the command script
   typedef enum logic [2:0] {
      CK_DESEL = 3'd0,
      CK_PRE   = 3'd1,
      CK_REF   = 3'd2,
      CK_MRS   = 3'd3,
      CK_EMRS  = 3'd4,
      CK_EMRS2 = 3'd5,
      CK_EMRS3 = 3'd6
   } cmd_kind_t;

   // one packed script entry: code lands in [23:16], argument in [15:0]
   typedef struct packed {
      logic [7:0]  code;
      logic [15:0] arg;
   } cmd_word_t;

   localparam int unsigned NUM_CMDS    = 12;
   localparam int unsigned STEP_CMD0   = 3;
   localparam int unsigned STEP_TIMING = STEP_CMD0 + NUM_CMDS;
   localparam int unsigned NUM_STEPS   = STEP_TIMING + 3;
   localparam int unsigned STEP_W      = $clog2(NUM_STEPS);
   localparam int unsigned CMD_IDX_W   = $clog2(NUM_CMDS);

endpackage

// File: rtl/ddr2_boot_delay.sv
module ddr2_boot_delay #(
   parameter int unsigned DELAY_CNT = 10000
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   output logic expired
);
   localparam int unsigned CW = (DELAY_CNT > 1) ? $clog2(DELAY_CNT) : 1;
   localparam logic [CW-1:0] RELOAD = CW'(DELAY_CNT - 1);

   logic [CW-1:0] cnt_q;

   initial begin
      assert (DELAY_CNT >= 1) else $error("DELAY_CNT must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst)               cnt_q <= RELOAD;
      else if (load)         cnt_q <= RELOAD;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

   // R2 / R7: the counter walks down by one each idle cycle
   p_countdown_r7: assert property (@(posedge clk) disable iff (rst)
      (!load && !expired) |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));

   generate
      if (DELAY_CNT > 1) begin : g_long
         // R2: a fresh load never expires on the following cycle
         p_load_fresh_r2: assert property (@(posedge clk) disable iff (rst)
            load |=> !expired);
      end else begin : g_short
         // R7: a one-cycle wait expires immediately after load
         p_load_short_r7: assert property (@(posedge clk) disable iff (rst)
            load |=> expired);
      end
   endgenerate

endmodule

// File: rtl/ddr2_boot_script.sv
module ddr2_boot_script
   import ddr2_boot_pkg::*;
#(
   parameter int unsigned    ADDR_W          = 8,
   parameter logic [ADDR_W-1:0] A_PHY_CFG    = 'h00,
   parameter logic [ADDR_W-1:0] A_PHY_CTRL   = 'h04,
   parameter logic [ADDR_W-1:0] A_CMD        = 'h08,
   parameter logic [ADDR_W-1:0] A_TIMING     = 'h0C,
   parameter logic [ADDR_W-1:0] A_LATENCY    = 'h10,
   parameter logic [ADDR_W-1:0] A_CFG        = 'h14,
   parameter int unsigned    PHY_CLK_EN_BIT  = 0,
   parameter int unsigned    PHY_RST_BIT     = 0,
   parameter int unsigned    PHY_CAL_RST_BIT = 1,
   parameter int unsigned    PHY_CAL_GO_BIT  = 2,
   parameter logic [7:0]     OP_DESEL        = 8'h00,
   parameter logic [7:0]     OP_PRE          = 8'h01,
   parameter logic [7:0]     OP_REF          = 8'h02,
   parameter logic [7:0]     OP_MRS          = 8'h03,
   parameter logic [7:0]     OP_EMRS         = 8'h04,
   parameter logic [7:0]     OP_EMRS2        = 8'h05,
   parameter logic [7:0]     OP_EMRS3        = 8'h06,
   parameter logic [15:0]    ARG_PRE_ALL     = 16'h0400,
   parameter logic [15:0]    ARG_DLL_ON      = 16'h0001,
   parameter logic [15:0]    ARG_DLL_RESET   = 16'h0100,
   parameter logic [15:0]    ARG_OCD_DEFAULT = 16'h0380,
   parameter logic [15:0]    ARG_OCD_EXIT    = 16'h0040
) (
   input  logic [STEP_W-1:0] step,
   input  logic [31:0]       mode_cfg,
   input  logic [31:0]       timing_cfg,
   input  logic [31:0]       latency_cfg,
   input  logic [31:0]       ctrl_cfg,
   output logic [ADDR_W-1:0] addr,
   output logic [31:0]       data,
   output logic              pause_after,
   output logic              last
);

   initial begin
      assert (PHY_CLK_EN_BIT < 32 && PHY_RST_BIT < 32 &&
              PHY_CAL_RST_BIT < 32 && PHY_CAL_GO_BIT < 32)
         else $error("PHY bit positions must lie inside the 32-bit word");
      assert (PHY_CAL_GO_BIT != PHY_RST_BIT && PHY_CAL_GO_BIT != PHY_CAL_RST_BIT)
         else $error("calibration-go bit must differ from the reset bits");
   end

   localparam logic [31:0] PHY_CLK_WORD  = 32'(1) << PHY_CLK_EN_BIT;
   localparam logic [31:0] PHY_RST_WORD  = (32'(1) << PHY_RST_BIT) |
                                           (32'(1) << PHY_CAL_RST_BIT);
   localparam logic [31:0] PHY_GO_WORD   = 32'(1) << PHY_CAL_GO_BIT;

   // which command kind sits at each script slot (order is behaviour)
   function automatic cmd_kind_t kind_at(input int unsigned k);
      case (k)
         0:       return CK_DESEL;
         1, 6:    return CK_PRE;
         2:       return CK_EMRS2;
         3:       return CK_EMRS3;
         5, 9:    return CK_MRS;
         7, 8:    return CK_REF;
         default: return CK_EMRS;
      endcase
   endfunction

   function automatic logic [7:0] code_of(input cmd_kind_t kd);
      case (kd)
         CK_DESEL: return OP_DESEL;
         CK_PRE:   return OP_PRE;
         CK_REF:   return OP_REF;
         CK_MRS:   return OP_MRS;
         CK_EMRS:  return OP_EMRS;
         CK_EMRS2: return OP_EMRS2;
         default:  return OP_EMRS3;
      endcase
   endfunction

   function automatic logic [15:0] arg_at(input int unsigned k, input logic [31:0] mw);
      case (k)
         1, 6:    return ARG_PRE_ALL;
         4:       return ARG_DLL_ON;
         5:       return ARG_DLL_RESET;
         9:       return mw[15:0];
         10:      return ARG_OCD_DEFAULT | ARG_DLL_ON;
         11:      return ARG_OCD_EXIT | ARG_DLL_ON | mw[31:16];
         default: return 16'h0000;
      endcase
   endfunction

   cmd_word_t table_w [NUM_CMDS];

   generate
      for (genvar k = 0; k < NUM_CMDS; k++) begin : g_slot
         assign table_w[k] = '{code: code_of(kind_at(k)), arg: arg_at(k, mode_cfg)};
      end
   endgenerate

   logic [CMD_IDX_W-1:0] cmd_idx;
   assign cmd_idx = CMD_IDX_W'(step - STEP_W'(STEP_CMD0));

   always_comb begin
      addr        = A_CFG;
      data        = ctrl_cfg;
      pause_after = 1'b0;
      last        = 1'b0;
      if (step == STEP_W'(0)) begin
         addr        = A_PHY_CFG;
         data        = PHY_CLK_WORD;
         pause_after = 1'b1;
      end else if (step == STEP_W'(1)) begin
         addr = A_PHY_CTRL;
         data = PHY_RST_WORD;
      end else if (step == STEP_W'(2)) begin
         addr        = A_PHY_CTRL;
         data        = PHY_GO_WORD;
         pause_after = 1'b1;
      end else if (step < STEP_W'(STEP_TIMING)) begin
         addr        = A_CMD;
         data        = {8'h00, table_w[cmd_idx]};
         pause_after = 1'b1;
      end else if (step == STEP_W'(STEP_TIMING)) begin
         addr = A_TIMING;
         data = timing_cfg;
      end else if (step == STEP_W'(STEP_TIMING + 1)) begin
         addr = A_LATENCY;
         data = latency_cfg;
      end else begin
         last = 1'b1;
      end
   end

endmodule

// File: rtl/ddr2_boot_seq.sv
module ddr2_boot_seq
   import ddr2_boot_pkg::*;
#(
   parameter int unsigned    ADDR_W          = 8,
   parameter int unsigned    DELAY_CNT       = 10000,
   parameter bit             USE_START       = 1'b1,
   parameter logic [ADDR_W-1:0] A_PHY_CFG    = 'h00,
   parameter logic [ADDR_W-1:0] A_PHY_CTRL   = 'h04,
   parameter logic [ADDR_W-1:0] A_CMD        = 'h08,
   parameter logic [ADDR_W-1:0] A_TIMING     = 'h0C,
   parameter logic [ADDR_W-1:0] A_LATENCY    = 'h10,
   parameter logic [ADDR_W-1:0] A_CFG        = 'h14,
   parameter int unsigned    PHY_CLK_EN_BIT  = 0,
   parameter int unsigned    PHY_RST_BIT     = 0,
   parameter int unsigned    PHY_CAL_RST_BIT = 1,
   parameter int unsigned    PHY_CAL_GO_BIT  = 2,
   parameter logic [7:0]     OP_DESEL        = 8'h00,
   parameter logic [7:0]     OP_PRE          = 8'h01,
   parameter logic [7:0]     OP_REF          = 8'h02,
   parameter logic [7:0]     OP_MRS          = 8'h03,
   parameter logic [7:0]     OP_EMRS         = 8'h04,
   parameter logic [7:0]     OP_EMRS2        = 8'h05,
   parameter logic [7:0]     OP_EMRS3        = 8'h06,
   parameter logic [15:0]    ARG_PRE_ALL     = 16'h0400,
   parameter logic [15:0]    ARG_DLL_ON      = 16'h0001,
   parameter logic [15:0]    ARG_DLL_RESET   = 16'h0100,
   parameter logic [15:0]    ARG_OCD_DEFAULT = 16'h0380,
   parameter logic [15:0]    ARG_OCD_EXIT    = 16'h0040
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [31:0]       mode_cfg,
   input  logic [31:0]       timing_cfg,
   input  logic [31:0]       latency_cfg,
   input  logic [31:0]       ctrl_cfg,
   output logic              wr_valid,
   input  logic              wr_ready,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [31:0]       wr_data,
   output logic              busy,
   output logic              done
);

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= 32) else $error("ADDR_W out of range");
   end

   seq_state_t        state_q, state_d;
   logic [STEP_W-1:0] step_q, step_d;
   logic              tmr_load, tmr_done, go;
   logic              s_pause, s_last;

   // start gating variant
   generate
      if (USE_START) begin : g_gated
         assign go = start;
      end else begin : g_free
         logic unused_start;
         assign unused_start = start;
         assign go = 1'b1;
      end
   endgenerate

   ddr2_boot_delay #(.DELAY_CNT(DELAY_CNT)) u_delay (
      .clk     (clk),
      .rst     (rst),
      .load    (tmr_load),
      .expired (tmr_done)
   );

   ddr2_boot_script #(
      .ADDR_W(ADDR_W), .A_PHY_CFG(A_PHY_CFG), .A_PHY_CTRL(A_PHY_CTRL), .A_CMD(A_CMD),
      .A_TIMING(A_TIMING), .A_LATENCY(A_LATENCY), .A_CFG(A_CFG),
      .PHY_CLK_EN_BIT(PHY_CLK_EN_BIT), .PHY_RST_BIT(PHY_RST_BIT),
      .PHY_CAL_RST_BIT(PHY_CAL_RST_BIT), .PHY_CAL_GO_BIT(PHY_CAL_GO_BIT),
      .OP_DESEL(OP_DESEL), .OP_PRE(OP_PRE), .OP_REF(OP_REF), .OP_MRS(OP_MRS),
      .OP_EMRS(OP_EMRS), .OP_EMRS2(OP_EMRS2), .OP_EMRS3(OP_EMRS3),
      .ARG_PRE_ALL(ARG_PRE_ALL), .ARG_DLL_ON(ARG_DLL_ON), .ARG_DLL_RESET(ARG_DLL_RESET),
      .ARG_OCD_DEFAULT(ARG_OCD_DEFAULT), .ARG_OCD_EXIT(ARG_OCD_EXIT)
   ) u_script (
      .step        (step_q),
      .mode_cfg    (mode_cfg),
      .timing_cfg  (timing_cfg),
      .latency_cfg (latency_cfg),
      .ctrl_cfg    (ctrl_cfg),
      .addr        (wr_addr),
      .data        (wr_data),
      .pause_after (s_pause),
      .last        (s_last)
   );

   always_comb begin
      state_d  = state_q;
      step_d   = step_q;
      tmr_load = 1'b0;
      unique case (state_q)
         SEQ_IDLE: begin
            if (go) begin
               state_d  = SEQ_WAIT;
               tmr_load = 1'b1;
            end
         end
         SEQ_WAIT: begin
            if (tmr_done) state_d = SEQ_WRITE;
         end
         SEQ_WRITE: begin
            if (wr_ready) begin
               if (s_last) begin
                  state_d = SEQ_DONE;
               end else begin
                  step_d = step_q + 1'b1;
                  if (s_pause) begin
                     state_d  = SEQ_WAIT;
                     tmr_load = 1'b1;
                  end
               end
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_IDLE;
         step_q  <= '0;
      end else begin
         state_q <= state_d;
         step_q  <= step_d;
      end
   end

   assign wr_valid = (state_q == SEQ_WRITE);
   assign busy     = (state_q == SEQ_WAIT) || (state_q == SEQ_WRITE);
   assign done     = (state_q == SEQ_DONE);

   // R9: a stalled write keeps its address, data and step
   p_hold_stall_r9: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

   // R7: an accepted paused step leaves the port idle next cycle
   p_pause_idle_r7: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && wr_ready && s_pause) |=> (!wr_valid && busy));

   // R4 / R8: an accepted unpaused, non-final step presents the next write at once
   p_back_to_back_r8: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && wr_ready && !s_pause && !s_last) |=> wr_valid);

   // R10: acceptance of the final write raises done
   p_done_rise_r10: assert property (@(posedge clk) disable iff (rst)
      (wr_valid && wr_ready && s_last) |=> (done && !busy));

   // R10: done is sticky until reset
   p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
      done |=> done);

   // R2: leaving idle loads the wait timer
   p_idle_exit_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(busy) |-> $past(tmr_load));

endmodule

// File: tb/ddr2_boot_seq_test.sv
module ddr2_boot_seq_test;
   localparam int unsigned D = 5;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        start = 1'b0;
   logic [31:0] mode_cfg = 32'h0, timing_cfg = 32'h0, latency_cfg = 32'h0, ctrl_cfg = 32'h0;
   logic        wr_valid, wr_ready = 1'b1, busy, done;
   logic [7:0]  wr_addr;
   logic [31:0] wr_data;

   int nchk = 0, nerr = 0;
   int idx = 0, gap = 0, rdy_mode = 0, cyc = 0, wd = 0;
   bit finished = 0;
   bit stalled = 0;
   logic [7:0]  st_addr;
   logic [31:0] st_data;

   always #5 clk = ~clk;

   ddr2_boot_seq #(.DELAY_CNT(D), .USE_START(1'b1)) uut (
      .clk(clk), .rst(rst), .start(start), .mode_cfg(mode_cfg),
      .timing_cfg(timing_cfg), .latency_cfg(latency_cfg), .ctrl_cfg(ctrl_cfg),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .done(done)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // expected write list, computed from the requirement text
   function automatic logic [7:0] exp_addr(input int i);
      if (i == 0)       return 8'h00;
      else if (i <= 2)  return 8'h04;
      else if (i <= 14) return 8'h08;
      else if (i == 15) return 8'h0C;
      else if (i == 16) return 8'h10;
      else              return 8'h14;
   endfunction

   function automatic logic [31:0] cmd(input int code, input int arg);
      return (32'(code) << 16) | 32'(arg);
   endfunction

   function automatic logic [31:0] exp_data(input int i);
      case (i)
         0:  return 32'h1;
         1:  return 32'h3;
         2:  return 32'h4;
         3:  return cmd(0, 0);
         4:  return cmd(1, 'h0400);
         5:  return cmd(5, 0);
         6:  return cmd(6, 0);
         7:  return cmd(4, 'h0001);
         8:  return cmd(3, 'h0100);
         9:  return cmd(1, 'h0400);
         10: return cmd(2, 0);
         11: return cmd(2, 0);
         12: return cmd(3, int'(mode_cfg[15:0]));
         13: return cmd(4, 'h0381);
         14: return cmd(4, int'(16'h0041 | mode_cfg[31:16]));
         15: return timing_cfg;
         16: return latency_cfg;
         default: return ctrl_cfg;
      endcase
   endfunction

   function automatic int exp_gap(input int i);
      return (i == 2 || i == 16 || i == 17) ? 0 : int'(D);
   endfunction

   function automatic string data_req(input int i);
      if (i == 0)                 return "R3";
      else if (i <= 2)            return "R4";
      else if (i == 12 || i == 14) return "R6";
      else if (i <= 14)           return "R5";
      else                        return "R8";
   endfunction

   function automatic string gap_req(input int i);
      if (i == 0)                 return "R2";
      else if (i == 1)            return "R3";
      else if (i <= 3)            return "R4";
      else if (i <= 15)           return "R7";
      else                        return "R8";
   endfunction

   // acceptance model for the register sink
   always @(posedge clk) begin
      #1;
      cyc++;
      case (rdy_mode)
         0:       wr_ready = 1'b1;
         1:       wr_ready = (cyc % 3 == 0);
         default: wr_ready = (cyc % 3 != 0);
      endcase
   end

   // monitor: log and check each accepted write at the falling edge
   always @(negedge clk) begin
      if (rst) begin
         idx = 0; gap = 0; stalled = 0;
      end else begin
         if (stalled && wr_valid) begin
            check("R9 stall addr", 32'(wr_addr), 32'(st_addr));
            check("R9 stall data", wr_data, st_data);
         end
         stalled = 0;
         if (busy && !wr_valid) gap++;
         if (wr_valid && wr_ready) begin
            if (idx < 18) begin
               check({data_req(idx), " addr"}, 32'(wr_addr), 32'(exp_addr(idx)));
               check({data_req(idx), " data"}, wr_data, exp_data(idx));
               check({gap_req(idx), " gap"}, 32'(gap), 32'(exp_gap(idx)));
            end else begin
               check("R9 extra write", 32'(idx), 32'd17);
            end
            idx++;
            gap = 0;
         end else if (wr_valid) begin
            stalled = 1; st_addr = wr_addr; st_data = wr_data;
         end
      end
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 100000 && !finished) begin
         finished = 1;
         nchk++; nerr++;
         $display("FAIL watchdog: actual %0d cycles expected completion", wd);
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
         $finish;
      end
   end

   task automatic pulse_reset();
      @(posedge clk); #1 rst = 1'b1;
      @(posedge clk); #1 rst = 1'b0;
      @(negedge clk);
      check("R11 valid after reset", 32'(wr_valid), 32'd0);
      check("R1 busy after reset", 32'(busy), 32'd0);
      check("R1 done after reset", 32'(done), 32'd0);
   endtask

   task automatic hold_idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         check("R1 no write before start", 32'(wr_valid), 32'd0);
         check("R1 idle busy", 32'(busy), 32'd0);
      end
   endtask

   task automatic kick();
      @(posedge clk); #1 start = 1'b1;
      @(posedge clk); #1 start = 1'b0;
      @(negedge clk);
      check("R10 busy after start", 32'(busy), 32'd1);
   endtask

   task automatic finish_run();
      wait (idx == 18);
      @(negedge clk);
      check("R10 done after final write", 32'(done), 32'd1);
      check("R10 busy cleared", 32'(busy), 32'd0);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         check("R10 done sticky", 32'(done), 32'd1);
         check("R10 quiet after done", 32'(wr_valid), 32'd0);
      end
      check("R9 write count", 32'(idx), 32'd18);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      hold_idle(6);

      // run 1: always-ready sink
      rdy_mode = 0;
      mode_cfg = 32'hA5C3_1234; timing_cfg = 32'h1111_2222;
      latency_cfg = 32'h0000_0305; ctrl_cfg = 32'hDEAD_0001;
      kick();
      finish_run();

      // run 2: sink accepts one cycle in three
      pulse_reset();
      hold_idle(3);
      rdy_mode = 1;
      mode_cfg = 32'h0F0F_4242; timing_cfg = 32'h7654_3210;
      latency_cfg = 32'h0000_0406; ctrl_cfg = 32'h0BAD_F00D;
      kick();
      finish_run();

      // run 3: reset partway through, then full replay (R11)
      pulse_reset();
      rdy_mode = 2;
      mode_cfg = 32'h8001_7E00; timing_cfg = 32'h0102_0304;
      latency_cfg = 32'h0000_0203; ctrl_cfg = 32'hC0FF_EE00;
      kick();
      wait (idx == 8);
      pulse_reset();
      hold_idle(4);
      check("R11 replay starts at first write", 32'(idx), 32'd0);
      kick();
      finish_run();

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
   end

endmodule